// File: doc/BRIEF.md
# Extended-Resolution PWM with Duty Stretching

This block generates one pulse-width-modulated output from an 8-bit period counter. The low six counter bits run a 64-step base frame. The top two bits number four consecutive frames. A 6-bit reference sets how many counter steps each frame stays high. A 2-bit extension code adds one extra high step to selected frames of the four-frame group. Over a 256-step period this gives a quarter-step of extra average duty resolution, while the output still switches at the frame rate.

Software programs two 8-bit registers through a single write port. The data register carries the reference and the extension code. The control register carries a run bit and a rate select. The rate select sets how often the counter advances, as a division of the input clock. Clearing the run bit freezes the counter, and setting it again continues from the frozen value. While the counter runs, new data takes effect only when the counter wraps from 255 to 0, so a period is never mixed from two settings.

Top module: `stretch_pwm`

## Requirements
- R1: A write with `wr_sel`=0 loads the data register: bits 7..2 are the 6-bit reference, bits 1..0 the extension code. A write with `wr_sel`=1 loads the control register.
- R2: Control bit 2 set to 1 runs the counter. Clearing it freezes the count, and a later set resumes from the frozen count, not from zero.
- R3: After reset the output is low, the counter is stopped at 0 and the prescaler is cleared. The output stays low until the run bit is set, whatever data has been written.
- R4: In a frame that is not stretched, a nonzero reference N keeps the output high for N counter steps from the start of the frame, and low for the rest of it.
- R5: A reference of 0 keeps the output low in every frame, whatever the extension code.
- R6: Frames are numbered 0 to 3 by counter bits 7..6. Extension bit 1 stretches frames 0 and 2 and extension bit 0 stretches frame 1, each by one extra high step. Frame 3 is never stretched, and code 00 stretches nothing.
- R7: With a reference of 63, a stretched frame stays high for all 64 steps.
- R8: Control bits 7..6 set the counter step rate: 00 is every clock, 01 every 2, 10 every 8 and 11 every 64 clocks.
- R9: A data write while the counter runs takes effect only at the next wrap from 255 to 0. A write while the counter is stopped takes effect at once.
- R10: While the counter is stopped the output holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 data, 1 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a data write landing in the middle of a running period. To show it is deferred, the high-time pattern has to be observed across the wrap that follows. The bench starts from reset so that the frame phase is known. It writes a new reference during frame 1 and measures the next three high pulses: two pulses at the old width, then one at the new width. Resuming from a frozen count is shown in a similar way. The bench stops the counter mid-frame for two different lengths of time and checks that the wait to the next rising edge is the same in both cases and far from a fresh start.

// File: rtl/stretch_pwm.sv
module stretch_pwm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_out
);
  logic [5:0] sh_ref, ac_ref;
  logic [1:0] sh_ext, ac_ext;
  logic       run;
  logic [1:0] rate;
  logic [5:0] pre, pre_max;
  logic [7:0] cnt;
  logic       tick, load, stretch, high_now;

  always_comb begin
    case (rate)
      2'd0:    pre_max = 6'd0;
      2'd1:    pre_max = 6'd1;
      2'd2:    pre_max = 6'd7;
      default: pre_max = 6'd63;
    endcase
  end

  assign tick = run && (pre >= pre_max);
  assign load = !run || (tick && cnt == 8'hFF);

  always_comb begin
    case (cnt[7:6])
      2'd0:    stretch = ac_ext[1];
      2'd1:    stretch = ac_ext[0];
      2'd2:    stretch = ac_ext[1];
      default: stretch = 1'b0;
    endcase
  end

  assign high_now = (ac_ref != 6'd0) &&
                    ({1'b0, cnt[5:0]} < ({1'b0, ac_ref} + {6'd0, stretch}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ref <= '0;
      sh_ext <= '0;
      run    <= 1'b0;
      rate   <= '0;
    end else if (wr_en) begin
      if (!wr_sel) {sh_ref, sh_ext} <= wr_data[7:0];
      else begin
        rate <= wr_data[7:6];
        run  <= wr_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (run) pre <= tick ? 6'd0 : pre + 6'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_ref <= '0;
      ac_ext <= '0;
    end else if (load) begin
      ac_ref <= sh_ref;
      ac_ext <= sh_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else if (tick) begin
      cnt     <= cnt + 8'd1;
      pwm_out <= high_now;
    end
  end

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm_out));

  // R5
  zero_ref_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ac_ref == 6'd0) |=> !pwm_out);

  // R4
  frame_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt[5:0] == 6'd0 && ac_ref != 6'd0) |=> pwm_out);

  // R7
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ac_ref == 6'd63 && stretch) |=> pwm_out);

  // R9
  data_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt == 8'hFF)) |=> ($stable(ac_ref) && $stable(ac_ext)));

  // R6
  last_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 8'hFF) |=> !pwm_out || $past(ac_ref) == 6'd63);
endmodule

// File: tb/stretch_pwm_bench.sv
module stretch_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  stretch_pwm u_stretch_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // {data, ctrl, tag, expected high clocks over one full period}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {8'h80, 8'h04, 8'd4, 16'd128},
    {8'h81, 8'h04, 8'd6, 16'd129},
    {8'h82, 8'h04, 8'd6, 16'd130},
    {8'h83, 8'h04, 8'd6, 16'd131},
    {8'h07, 8'h04, 8'd6, 16'd7},
    {8'h03, 8'h04, 8'd5, 16'd0},
    {8'hFC, 8'h04, 8'd4, 16'd252},
    {8'hFF, 8'h04, 8'd7, 16'd255},
    {8'h45, 8'h04, 8'd1, 16'd69},
    {8'h80, 8'h44, 8'd8, 16'd256},
    {8'h80, 8'h84, 8'd8, 16'd1024},
    {8'h80, 8'hC4, 8'd8, 16'd8192}
  };

  function automatic string tag(input int t);
    case (t)
      1: return "R1";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int divof(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 64;
    endcase
  endfunction

  task automatic check(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic run_len(output int len);
    int guard = 0;
    len = 0;
    while (!pwm_out && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    while (pwm_out && len < 2000) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!pwm_out && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(190000 * 20);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int h, x1, x2, l0, l1, l2, l3;
    bit moved;
    do_reset();

    // R3: low after reset, stays low with data loaded but not running
    check("R3", pwm_out, 0);
    wr(1'b0, 8'h80);
    count_high(300, h);
    check("R3", h, 0);

    // table walk: total high clocks over one full period
    for (int v = 0; v < NV; v++) begin
      int d;
      d = divof(VEC[v][31:30]);
      wr(1'b1, 8'h00);
      wr(1'b0, VEC[v][39:32]);
      wr(1'b1, VEC[v][31:24]);
      repeat (d + 2) @(negedge clk);
      count_high(256 * d, h);
      check(tag(int'(VEC[v][23:16])), h, int'(VEC[v][15:0]));
    end

    // R6: per-frame pulse widths, code 01 then 10, phase known from reset
    do_reset();
    wr(1'b0, 8'h81);
    wr(1'b1, 8'h04);
    run_len(l0); run_len(l1); run_len(l2); run_len(l3);
    check("R6", l0, 32); check("R6", l1, 33);
    check("R6", l2, 32); check("R6", l3, 32);
    do_reset();
    wr(1'b0, 8'h82);
    wr(1'b1, 8'h04);
    run_len(l0); run_len(l1); run_len(l2); run_len(l3);
    check("R6", l0, 33); check("R6", l1, 32);
    check("R6", l2, 33); check("R6", l3, 32);

    // R2 / R10: stop mid-frame, resume continues from held count
    do_reset();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h04);
    repeat (40) @(negedge clk);
    wr(1'b1, 8'h00);
    @(negedge clk);
    wr(1'b1, 8'h04);
    wait_rise(x1);
    do_reset();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h04);
    repeat (40) @(negedge clk);
    wr(1'b1, 8'h00);
    moved = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwm_out) moved = 1;
    end
    check("R10", moved, 0);
    wr(1'b1, 8'h04);
    wait_rise(x2);
    check("R2", x2, x1);
    check("R2", (x1 >= 18 && x1 <= 30) ? 1 : 0, 1);

    // R9: write during frame 1 deferred to the wrap
    do_reset();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h04);
    repeat (100) @(negedge clk);
    wr(1'b0, 8'h20);
    run_len(l0); run_len(l1); run_len(l2);
    check("R9", l0, 32); check("R9", l1, 32); check("R9", l2, 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule